// File: doc/BRIEF.md
# I2C SCL Bus Timeout Monitor

This block guards an I2C controller against a clock line that never comes back up. The monitor arms when the local controller starts pulling SCL low. From then on it counts I2C bit-clock ticks for as long as SCL stays low. If the count reaches the programmed period before SCL is seen high, it latches a bus error. That error drives an interrupt flag and a forced-release signal, which makes the controller let go of both SCL and SDA.

The period is given in I2C clock ticks, not in system clocks. A period of zero turns the monitor off. The monitor watches only its own drive: if another device holds SCL low while the local drive is idle, the monitor does not arm. Software clears the error flag by writing one, and the forced release lasts until that write.

Top module: `scl_timeout_mon`

## Requirements
- R1: After reset, `err_o` and `release_o` are 0.
- R2: When `period_i` is 0, no error is ever raised, however long SCL is held low.
- R3: The monitor arms while `drive_low_i` is 1. With period P, `err_o` rises on the clock after the P-th `tick_i` seen while armed and SCL is low. After P-1 ticks it stays 0.
- R4: Only cycles with `tick_i` = 1 advance the count. Any number of system clocks without a tick raises no error.
- R5: SCL held low while `drive_low_i` is 0 does not arm the monitor.
- R6: SCL sampled high with the local drive released clears the count and disarms the monitor. A later drive needs a full P ticks again.
- R7: `err_o` stays at 1 until it is cleared, and `release_o` equals `err_o`.
- R8: A pulse on `clr_i` clears a pending error. When no error is pending, `clr_i` has no effect.
- R9: The count saturates and never wraps. If `period_i` is lowered to a value at or below the count already reached while armed, `err_o` rises on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse per I2C clock period |
| period_i | input | PERIOD_W | Timeout period in ticks, 0 disables |
| drive_low_i | input | 1 | Local controller is pulling SCL low |
| scl_i | input | 1 | Sampled SCL line level |
| clr_i | input | 1 | Write-one clear of the error flag |
| err_o | output | 1 | Bus timeout error flag |
| release_o | output | 1 | Forces the controller to release SCL and SDA |

## Verification
The bench builds the monitor with PERIOD_W = 4. At that width the all-ones period of 15 can be driven in a short run, so the saturating count is tested at its very top value, with no wrap back to zero. The narrow width also keeps each timeout vector short. This leaves room to test the exact P versus P-1 boundary at several periods, including 1, the zero-period disable, and lowering the period during a count.

// File: rtl/scl_to_pkg.sv
package scl_to_pkg;
  localparam int unsigned DEF_PERIOD_W = 16;
endpackage

// File: rtl/scl_to_arm.sv
module scl_to_arm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic drive_low_i,
  input  logic scl_i,
  input  logic err_i,
  output logic armed_o
);
  logic armed_q;

  // arms only on local drive; holds until SCL seen high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= en_i && !err_i && (drive_low_i || (armed_q && !scl_i));
  end

  assign armed_o = armed_q;

  a_r5_no_external_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed_q && !drive_low_i) |=> !armed_q);
endmodule

// File: rtl/scl_to_cnt.sv
module scl_to_cnt #(
  parameter int unsigned PERIOD_W = scl_to_pkg::DEF_PERIOD_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                armed_i,
  input  logic                rel_i,
  input  logic                tick_i,
  input  logic [PERIOD_W-1:0] period_i,
  output logic                hit_o
);
  logic [PERIOD_W-1:0] cnt_q;
  logic                at_lim;

  assign at_lim = (cnt_q >= period_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!armed_i || rel_i)  cnt_q <= '0;
    else if (tick_i && !at_lim)  cnt_q <= cnt_q + 1'b1;
  end

  assign hit_o = armed_i && (period_i != '0) && at_lim;

  a_r9_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_i && !rel_i && at_lim) |=> (cnt_q == $past(cnt_q)));
  a_r2_zero_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_i == '0) |-> !hit_o);
endmodule

// File: rtl/scl_to_flag.sv
module scl_to_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic clr_i,
  output logic err_o
);
  logic err_q;

  // a new hit wins over a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= hit_i || (err_q && !clr_i);
  end

  assign err_o = err_q;

  a_r3_hit_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i |=> err_q);
  a_r7_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !clr_i) |=> err_q);
  a_r8_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && clr_i && !hit_i) |=> !err_q);
endmodule

// File: rtl/scl_timeout_mon.sv
module scl_timeout_mon #(
  parameter int unsigned PERIOD_W = scl_to_pkg::DEF_PERIOD_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic [PERIOD_W-1:0] period_i,
  input  logic                drive_low_i,
  input  logic                scl_i,
  input  logic                clr_i,
  output logic                err_o,
  output logic                release_o
);
  logic armed, hit, err, en, rel;

  assign en  = (period_i != '0);
  assign rel = scl_i && !drive_low_i;

  scl_to_arm u_arm (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en), .drive_low_i(drive_low_i),
    .scl_i(scl_i), .err_i(err), .armed_o(armed)
  );

  scl_to_cnt #(.PERIOD_W(PERIOD_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .armed_i(armed), .rel_i(rel),
    .tick_i(tick_i), .period_i(period_i), .hit_o(hit)
  );

  scl_to_flag u_flag (
    .clk_i(clk_i), .rst_ni(rst_ni), .hit_i(hit), .clr_i(clr_i), .err_o(err)
  );

  assign err_o     = err;
  assign release_o = err;

  a_r7_release_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> $rose(release_o));
endmodule

// File: tb/scl_timeout_mon_bench.sv
module scl_timeout_mon_bench;
  localparam int unsigned PW = 4;
  // {period[4], ticks[8], expected err[4]}
  localparam int NV = 9;
  localparam logic [15:0] VEC [NV] = '{
    {4'd4, 8'd3, 4'd0}, {4'd4, 8'd4, 4'd1}, {4'd1, 8'd1, 4'd1},
    {4'd1, 8'd0, 4'd0}, {4'd0, 8'd20, 4'd0}, {4'd7, 8'd6, 4'd0},
    {4'd7, 8'd9, 4'd1}, {4'd15, 8'd14, 4'd0}, {4'd15, 8'd20, 4'd1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 1'b0, drv = 1'b0, scl = 1'b1, clr = 1'b0;
  logic [PW-1:0] per = '0;
  logic err, rel;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  scl_timeout_mon #(.PERIOD_W(PW)) u_scl_timeout_mon (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .period_i(per),
    .drive_low_i(drv), .scl_i(scl), .clr_i(clr), .err_o(err), .release_o(rel)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  task automatic idle_release();
    @(negedge clk) begin drv = 1'b0; scl = 1'b1; clr = 1'b1; end
    @(negedge clk) clr = 1'b0;
    @(negedge clk);
  endtask

  task automatic pull_low();
    @(negedge clk) begin drv = 1'b1; scl = 1'b0; end
  endtask

  initial begin
    #200000;
    n_bad++; n_chk++;
    $display("FAIL watchdog: got hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 err", err, 1'b0);
    chk("R1 release", rel, 1'b0);
    rst_n = 1'b1;

    // R3 R2 table walk
    for (int v = 0; v < NV; v++) begin
      idle_release();
      per = VEC[v][15:12];
      pull_low();
      ticks(int'(VEC[v][11:4]));
      @(negedge clk);
      chk($sformatf("R3 vec%0d", v), err, VEC[v][0]);
    end

    // R4 no ticks
    idle_release(); per = 4'd2; pull_low();
    repeat (100) @(negedge clk);
    chk("R4 no tick", err, 1'b0);

    // R5 external hold
    idle_release();
    @(negedge clk) begin drv = 1'b0; scl = 1'b0; end
    ticks(30); @(negedge clk);
    chk("R5 external low", err, 1'b0);

    // R6 release resets count
    idle_release(); per = 4'd5; pull_low();
    ticks(4);
    @(negedge clk) begin drv = 1'b0; scl = 1'b1; end
    @(negedge clk);
    pull_low(); ticks(4); @(negedge clk);
    chk("R6 recount", err, 1'b0);
    ticks(1); @(negedge clk);
    chk("R6 full period", err, 1'b1);

    // R7 sticky and release
    @(negedge clk) begin drv = 1'b0; scl = 1'b1; end
    repeat (10) @(negedge clk);
    chk("R7 sticky", err, 1'b1);
    chk("R7 release", rel, 1'b1);

    // R8 clear
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
    chk("R8 cleared", err, 1'b0);
    chk("R8 release off", rel, 1'b0);
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
    per = 4'd3; pull_low(); ticks(2); @(negedge clk);
    chk("R8 idle clr no effect", err, 1'b0);
    ticks(1); @(negedge clk);
    chk("R8 idle clr then timeout", err, 1'b1);

    // R9 lowering period below count
    idle_release(); per = 4'd8; pull_low(); ticks(5); @(negedge clk);
    chk("R9 before", err, 1'b0);
    @(negedge clk) per = 4'd3;
    @(negedge clk);
    chk("R9 lowered period", err, 1'b1);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule